// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. The two source operands come from the register file and pass through forwarding selectors that can substitute a result held in the memory stage or in the write-back stage. A dedicated comparator then evaluates the condition. An adder forms the taken target from the incremented PC and the sign-extended 16-bit offset. A single select line tells fetch whether the next address is the incremented PC or the target. The architecture has one delay slot, so the instruction after the branch always runs and a taken branch never flushes anything.

Deciding this early creates a read-after-write hazard. When the value a branch needs is still being computed in the execute stage, or is being loaded and has not yet returned, the operand cannot be forwarded in time. The block then raises a stall request and keeps the select at the incremented PC until the operand can be forwarded. The logic is purely combinational. Nothing it produces is passed down into the decode/execute pipeline register.

Top module: `brr_decode_resolve`

## Requirements
- R1: `br_target` always equals `pc_plus4` plus `br_offset` sign-extended to 32 bits, modulo 2^32, with no scaling of the offset.
- R2: `br_kind` encodes the condition: 0 taken when the two operands are equal, 1 taken when they differ, 2 taken when operand A has bit 31 set, 3 taken when operand A has bit 31 clear. For codes 2 and 3 operand B is not used, and its register index can never cause a stall.
- R3: `pc_sel` is 1 (select the target) exactly when `br_valid` is 1, `stall` is 0 and the condition holds; otherwise it is 0 (select `pc_plus4`).
- R4: Each operand is resolved in this priority order: the memory-stage result when the memory stage writes that register and is not a load, then the write-back data when the write-back stage writes that register, then the register-file read data.
- R5: `stall` is 1 when a branch needs a source register that the execute stage will write (`ex_wen` set and `ex_dst` equal to the index), whatever kind of instruction sits in execute.
- R6: `stall` is 1 when a branch needs a source register that a load in the memory stage will write. Once that load reaches write-back, its data is forwarded and there is no stall.
- R7: Register index 0 always supplies the value zero, whatever the read data. It is never matched for forwarding and never causes a stall.
- R8: Whenever `stall` is 1, `pc_sel` is 0, and it stays 0 for as long as the stall lasts.
- R9: With `br_valid` at 0, both `pc_sel` and `stall` are 0, whatever hazards the pipeline fields show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_valid | input | 1 | Decode holds a conditional branch |
| br_kind | input | 2 | Condition code (see R2) |
| br_offset | input | 16 | Signed branch displacement |
| pc_plus4 | input | 32 | Address of the sequential next instruction |
| src_a_idx | input | 5 | Register index of operand A |
| src_b_idx | input | 5 | Register index of operand B |
| src_a_rdata | input | 32 | Register-file read data for operand A |
| src_b_rdata | input | 32 | Register-file read data for operand B |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination index |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_wen | input | 1 | Write-back stage writes a register |
| wb_dst | input | 5 | Write-back destination index |
| wb_data | input | 32 | Write-back data (ALU or load) |
| pc_sel | output | 1 | 1 selects `br_target` for fetch, 0 selects `pc_plus4` |
| br_target | output | 32 | Taken-branch address |
| stall | output | 1 | Hold decode and fetch this cycle |

## Verification
The hardest situation to reach is a pipeline in which several stages name the same register at once. Examples are a non-load result in memory competing with write-back data, a load walking from execute to memory to write-back under a waiting branch, and an execute-stage match on operand B of a sign test. Random stimulus draws register indices from a small set that includes register 0, so these collisions happen often. Directed sequences replay the compare-then-branch and load-then-branch walks cycle by cycle.

// File: rtl/brr_pkg.sv
package brr_pkg;

    typedef enum logic [1:0] {
        BR_EQ  = 2'b00,
        BR_NE  = 2'b01,
        BR_NEG = 2'b10,
        BR_NNG = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_RF   = 2'b00,
        SRC_MEM  = 2'b01,
        SRC_WB   = 2'b10,
        SRC_ZERO = 2'b11
    } fwd_src_e;

    typedef struct packed {
        fwd_src_e src;
        logic     busy;
    } fwd_sel_t;

    typedef struct packed {
        logic stall;
        logic pc_sel;
    } resolve_t;

endpackage

// File: rtl/brr_operand_fwd.sv
module brr_operand_fwd
    import brr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [RAW-1:0]  idx,
    input  logic [XLEN-1:0] rf_data,
    input  logic            needed,
    input  logic            ex_wen,
    input  logic [RAW-1:0]  ex_dst,
    input  logic            mem_wen,
    input  logic            mem_is_load,
    input  logic [RAW-1:0]  mem_dst,
    input  logic [XLEN-1:0] mem_result,
    input  logic            wb_wen,
    input  logic [RAW-1:0]  wb_dst,
    input  logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] value,
    output logic            busy
);

    fwd_sel_t sel_d;
    logic     is_zero;
    logic     hit_ex;
    logic     hit_mem;
    logic     hit_wb;

    assign is_zero = (idx == '0);
    assign hit_ex  = ex_wen  && (ex_dst  == idx) && !is_zero;
    assign hit_mem = mem_wen && (mem_dst == idx) && !is_zero;
    assign hit_wb  = wb_wen  && (wb_dst  == idx) && !is_zero;

    always_comb begin
        sel_d      = '0;
        sel_d.src  = SRC_RF;
        if (is_zero) begin
            sel_d.src = SRC_ZERO;
        end else if (hit_mem) begin
            sel_d.src = SRC_MEM;
        end else if (hit_wb) begin
            sel_d.src = SRC_WB;
        end
        sel_d.busy = needed && (hit_ex || (hit_mem && mem_is_load));
    end

    always_comb begin
        unique case (sel_d.src)
            SRC_ZERO: value = '0;
            SRC_MEM:  value = mem_result;
            SRC_WB:   value = wb_data;
            default:  value = rf_data;
        endcase
    end

    assign busy = sel_d.busy;

    always_comb begin
        if (idx == '0) begin
            AST_R0_NEVER_BUSY: assert (!busy && value == '0) else $error("register 0 busy or nonzero"); // R7
        end
        if (!needed) begin
            AST_UNNEEDED_NOT_BUSY: assert (!busy) else $error("unused operand flagged busy"); // R2
        end
    end

endmodule

// File: rtl/brr_cond.sv
module brr_cond
    import brr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            taken
);

    logic same;
    logic neg;

    assign same = ~|(opa ^ opb);
    assign neg  = opa[XLEN-1];

    always_comb begin
        unique case (kind)
            BR_EQ:   taken = same;
            BR_NE:   taken = !same;
            BR_NEG:  taken = neg;
            default: taken = !neg;
        endcase
    end

endmodule

// File: rtl/brr_target.sv
module brr_target #(
    parameter int XLEN  = 32,
    parameter int OFS_W = 16
) (
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [OFS_W-1:0] offset,
    output logic [XLEN-1:0]  target
);

    localparam int EXT_W = XLEN - OFS_W;

    logic [XLEN-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
    assign target  = pc_plus4 + ofs_ext;

endmodule

// File: rtl/brr_decode_resolve.sv
module brr_decode_resolve
    import brr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    parameter int OFS_W = 16
) (
    input  logic             br_valid,
    input  logic [1:0]       br_kind,
    input  logic [OFS_W-1:0] br_offset,
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [RAW-1:0]   src_a_idx,
    input  logic [RAW-1:0]   src_b_idx,
    input  logic [XLEN-1:0]  src_a_rdata,
    input  logic [XLEN-1:0]  src_b_rdata,
    input  logic             ex_wen,
    input  logic [RAW-1:0]   ex_dst,
    input  logic             mem_wen,
    input  logic             mem_is_load,
    input  logic [RAW-1:0]   mem_dst,
    input  logic [XLEN-1:0]  mem_result,
    input  logic             wb_wen,
    input  logic [RAW-1:0]   wb_dst,
    input  logic [XLEN-1:0]  wb_data,
    output logic             pc_sel,
    output logic [XLEN-1:0]  br_target,
    output logic             stall
);

    localparam int NUM_SRC = 2;

    br_kind_e        kind;
    logic [RAW-1:0]  idx_v  [NUM_SRC];
    logic [XLEN-1:0] rf_v   [NUM_SRC];
    logic [XLEN-1:0] opnd_v [NUM_SRC];
    logic            need_v [NUM_SRC];
    logic            busy_v [NUM_SRC];
    logic            taken;
    resolve_t        res_d;

    assign kind      = br_kind_e'(br_kind);
    assign idx_v[0]  = src_a_idx;
    assign idx_v[1]  = src_b_idx;
    assign rf_v[0]   = src_a_rdata;
    assign rf_v[1]   = src_b_rdata;
    assign need_v[0] = br_valid;
    assign need_v[1] = br_valid && (kind == BR_EQ || kind == BR_NE);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        brr_operand_fwd #(
            .XLEN(XLEN),
            .RAW (RAW)
        ) u_fwd (
            .idx        (idx_v[g]),
            .rf_data    (rf_v[g]),
            .needed     (need_v[g]),
            .ex_wen     (ex_wen),
            .ex_dst     (ex_dst),
            .mem_wen    (mem_wen),
            .mem_is_load(mem_is_load),
            .mem_dst    (mem_dst),
            .mem_result (mem_result),
            .wb_wen     (wb_wen),
            .wb_dst     (wb_dst),
            .wb_data    (wb_data),
            .value      (opnd_v[g]),
            .busy       (busy_v[g])
        );
    end

    brr_cond #(
        .XLEN(XLEN)
    ) u_cond (
        .kind (kind),
        .opa  (opnd_v[0]),
        .opb  (opnd_v[1]),
        .taken(taken)
    );

    brr_target #(
        .XLEN (XLEN),
        .OFS_W(OFS_W)
    ) u_target (
        .pc_plus4(pc_plus4),
        .offset  (br_offset),
        .target  (br_target)
    );

    always_comb begin
        res_d        = '0;
        res_d.stall  = busy_v[0] || busy_v[1];
        res_d.pc_sel = br_valid && !res_d.stall && taken;
    end

    assign stall  = res_d.stall;
    assign pc_sel = res_d.pc_sel;

    always_comb begin
        if (stall) begin
            AST_STALL_HOLDS_SEQ: assert (!pc_sel) else $error("redirect during stall"); // R8
        end
        if (!br_valid) begin
            AST_IDLE_QUIET: assert (!pc_sel && !stall) else $error("activity without branch"); // R9
        end
        if (br_valid && (kind == BR_NEG || kind == BR_NNG)) begin
            AST_SIGN_B_UNUSED: assert (!busy_v[1]) else $error("operand B stalls sign test"); // R2
        end
        if (pc_sel) begin
            AST_REDIRECT_NEEDS_TAKEN: assert (taken && br_valid) else $error("redirect not taken"); // R3
        end
    end

endmodule

// File: tb/brr_decode_resolve_tb.sv
module brr_decode_resolve_tb;

    logic        clk = 1'b0;
    logic        br_valid;
    logic [1:0]  br_kind;
    logic [15:0] br_offset;
    logic [31:0] pc_plus4;
    logic [4:0]  src_a_idx, src_b_idx;
    logic [31:0] src_a_rdata, src_b_rdata;
    logic        ex_wen;
    logic [4:0]  ex_dst;
    logic        mem_wen, mem_is_load;
    logic [4:0]  mem_dst;
    logic [31:0] mem_result;
    logic        wb_wen;
    logic [4:0]  wb_dst;
    logic [31:0] wb_data;
    logic        pc_sel;
    logic [31:0] br_target;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    brr_decode_resolve u_dut (
        .br_valid   (br_valid),
        .br_kind    (br_kind),
        .br_offset  (br_offset),
        .pc_plus4   (pc_plus4),
        .src_a_idx  (src_a_idx),
        .src_b_idx  (src_b_idx),
        .src_a_rdata(src_a_rdata),
        .src_b_rdata(src_b_rdata),
        .ex_wen     (ex_wen),
        .ex_dst     (ex_dst),
        .mem_wen    (mem_wen),
        .mem_is_load(mem_is_load),
        .mem_dst    (mem_dst),
        .mem_result (mem_result),
        .wb_wen     (wb_wen),
        .wb_dst     (wb_dst),
        .wb_data    (wb_data),
        .pc_sel     (pc_sel),
        .br_target  (br_target),
        .stall      (stall)
    );

    function automatic logic [31:0] e_opnd(input logic [4:0] idx, input logic [31:0] rf);
        if (idx == 5'd0) return 32'd0;
        if (mem_wen && mem_dst == idx && !mem_is_load) return mem_result;
        if (wb_wen && wb_dst == idx) return wb_data;
        return rf;
    endfunction

    function automatic logic e_busy(input logic [4:0] idx, input logic need);
        if (!need || idx == 5'd0) return 1'b0;
        return (ex_wen && ex_dst == idx) || (mem_wen && mem_is_load && mem_dst == idx);
    endfunction

    function automatic logic e_stall();
        logic need_b;
        need_b = br_valid && (br_kind == 2'd0 || br_kind == 2'd1);
        return e_busy(src_a_idx, br_valid) || e_busy(src_b_idx, need_b);
    endfunction

    function automatic logic e_taken();
        logic [31:0] a, b;
        a = e_opnd(src_a_idx, src_a_rdata);
        b = e_opnd(src_b_idx, src_b_rdata);
        case (br_kind)
            2'd0:    return a == b;
            2'd1:    return a != b;
            2'd2:    return a[31];
            default: return !a[31];
        endcase
    endfunction

    function automatic logic [31:0] e_target();
        return pc_plus4 + {{16{br_offset[15]}}, br_offset};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        logic es;
        es = e_stall();
        chk(tag, "stall", {31'd0, stall}, {31'd0, es});
        chk(tag, "pc_sel", {31'd0, pc_sel}, {31'd0, br_valid && !es && e_taken()});
        chk("R1", "target", br_target, e_target());
    endtask

    task automatic clear_pipe();
        ex_wen = 0; ex_dst = 0; mem_wen = 0; mem_is_load = 0; mem_dst = 0;
        mem_result = 0; wb_wen = 0; wb_dst = 0; wb_data = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 4))
            0:       return 32'd0;
            1:       return 32'd5;
            2:       return 32'h8000_0000;
            3:       return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4711));
        br_valid = 0; br_kind = 0; br_offset = 0; pc_plus4 = 32'h100;
        src_a_idx = 0; src_b_idx = 0; src_a_rdata = 0; src_b_rdata = 0;
        clear_pipe();
        settle();
        // R9 quiet with no branch, even with a full hazard pattern
        chk("R9", "idle stall", {31'd0, stall}, 32'd0);
        chk("R9", "idle pc_sel", {31'd0, pc_sel}, 32'd0);
        step();
        src_a_idx = 3; src_b_idx = 3; ex_wen = 1; ex_dst = 3;
        settle();
        chk("R9", "idle with hazard stall", {31'd0, stall}, 32'd0);

        // R5: compare result in EX feeds branch-not-equal against r0
        step();
        clear_pipe();
        br_valid = 1; br_kind = 2'd1; src_a_idx = 8; src_b_idx = 0;
        src_a_rdata = 32'd0; ex_wen = 1; ex_dst = 8;
        settle();
        chk("R5", "ex hazard stall", {31'd0, stall}, 32'd1);
        chk("R8", "pc_sel held", {31'd0, pc_sel}, 32'd0);
        // next cycle the compare result sits in MEM as a non-load: forwarded
        step();
        clear_pipe(); mem_wen = 1; mem_dst = 8; mem_result = 32'd1;
        settle();
        chk("R4", "mem forward stall", {31'd0, stall}, 32'd0);
        chk("R4", "mem forward taken", {31'd0, pc_sel}, 32'd1);

        // R6: load walks EX -> MEM -> WB under an equality branch
        step();
        clear_pipe(); br_kind = 2'd0; src_a_idx = 4; src_b_idx = 9;
        src_a_rdata = 32'd77; src_b_rdata = 32'd0;
        ex_wen = 1; ex_dst = 9;
        settle();
        chk("R5", "load in ex", {31'd0, stall}, 32'd1);
        step();
        clear_pipe(); mem_wen = 1; mem_is_load = 1; mem_dst = 9; mem_result = 32'd0;
        settle();
        chk("R6", "load in mem", {31'd0, stall}, 32'd1);
        chk("R8", "load in mem pc_sel", {31'd0, pc_sel}, 32'd0);
        step();
        clear_pipe(); wb_wen = 1; wb_dst = 9; wb_data = 32'd77;
        settle();
        chk("R6", "load in wb stall", {31'd0, stall}, 32'd0);
        chk("R6", "load in wb taken", {31'd0, pc_sel}, 32'd1);

        // R4 priority: MEM over WB on the same register
        step();
        clear_pipe(); br_kind = 2'd0; src_a_idx = 5; src_b_idx = 6;
        src_a_rdata = 32'd1; src_b_rdata = 32'd2;
        mem_wen = 1; mem_dst = 5; mem_result = 32'd2;
        wb_wen = 1; wb_dst = 5; wb_data = 32'd3;
        settle();
        chk("R4", "mem over wb", {31'd0, pc_sel}, 32'd1);

        // R7: r0 never forwards, never stalls, reads zero
        step();
        clear_pipe(); br_kind = 2'd0; src_a_idx = 0; src_b_idx = 0;
        src_a_rdata = 32'hDEAD; src_b_rdata = 32'h0;
        ex_wen = 1; ex_dst = 0; mem_wen = 1; mem_is_load = 1; mem_dst = 0;
        settle();
        chk("R7", "r0 stall", {31'd0, stall}, 32'd0);
        chk("R7", "r0 reads zero", {31'd0, pc_sel}, 32'd1);

        // R2: sign test ignores operand B hazard
        step();
        clear_pipe(); br_kind = 2'd2; src_a_idx = 2; src_b_idx = 7;
        src_a_rdata = 32'h8000_0001; ex_wen = 1; ex_dst = 7;
        settle();
        chk("R2", "sign test B hazard", {31'd0, stall}, 32'd0);
        chk("R2", "negative taken", {31'd0, pc_sel}, 32'd1);
        step();
        br_kind = 2'd3;
        settle();
        chk("R2", "non-negative not taken", {31'd0, pc_sel}, 32'd0);

        // R1: negative offset and wrap
        step();
        clear_pipe(); br_valid = 0; pc_plus4 = 32'h0000_0004; br_offset = 16'hFFF0;
        settle();
        chk("R1", "negative offset wrap", br_target, 32'hFFFF_FFF4);
        step();
        pc_plus4 = 32'h1000; br_offset = 16'h7FFC;
        settle();
        chk("R1", "positive offset", br_target, 32'h0000_8FFC);

        // random mix: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4000; i++) begin
            step();
            br_valid    = ($urandom_range(0, 7) != 0);
            br_kind     = 2'($urandom_range(0, 3));
            br_offset   = 16'($urandom);
            pc_plus4    = $urandom;
            src_a_idx   = 5'($urandom_range(0, 3));
            src_b_idx   = 5'($urandom_range(0, 3));
            src_a_rdata = pick_val();
            src_b_rdata = pick_val();
            ex_wen      = ($urandom_range(0, 3) == 0);
            ex_dst      = 5'($urandom_range(0, 3));
            mem_wen     = $urandom_range(0, 1) == 1;
            mem_is_load = ($urandom_range(0, 3) == 0);
            mem_dst     = 5'($urandom_range(0, 3));
            mem_result  = pick_val();
            wb_wen      = $urandom_range(0, 1) == 1;
            wb_dst      = 5'($urandom_range(0, 3));
            wb_data     = pick_val();
            settle();
            chk_all("R3 R5 R6 R8");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule